// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit produces the memory address for a single load or store and the updated value of its base register. It takes the base register value and an offset that is either a 12-bit immediate from the instruction or a second register passed through a shifter. The shift type and amount also come from the instruction. Control bits select whether the offset is added or subtracted and whether it is applied before or after the access. They also decide whether the changed base goes back to the register file and whether the access is performed as a non-privileged one.

Indexing works in two ways. In the pre-indexed form the changed base is the address, and it is written back only when asked. In the post-indexed form the original base is the address and the changed base is always written back. In that form the writeback bit has a second job: in privileged code it forces the access to be made with user rights. The logic is combinational and ends in one register stage, so each result appears on the cycle after its valid input.

Top module: `ls_addr_gen`

## Requirements
- R1: With `off_is_reg`=0 the offset is `imm_off` zero-extended to the data width and `reg_off` has no effect. With `off_is_reg`=1 the offset is the shifted `reg_off` and `imm_off` has no effect.
- R2: The shift type `sh_kind` is encoded as 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right and 2'b11 rotate right. It uses the 5-bit amount `sh_amt`, and an amount of 0 passes the register through unchanged.
- R3: With `add_off`=1 the changed base is base plus offset. With `add_off`=0 it is base minus offset. Both wrap modulo 2^32.
- R4: `new_base` always carries the changed base. `xfer_addr` equals the changed base when `pre_idx`=1 and the unmodified base when `pre_idx`=0.
- R5: `base_we` is 1 for a post-indexed transfer whatever `wback` says. For a pre-indexed transfer it is 1 only when `wback`=1.
- R6: `force_user` is 1 when `priv`=0 (user mode, whatever the indexing bits say). It is also 1 for a post-indexed transfer with `wback`=1. In every other case it is 0.
- R7: Results appear on the outputs on the clock edge after the edge that samples `in_valid`=1, and `out_valid` is 1 in that cycle. A new operation is accepted every cycle.
- R8: In a cycle that follows an edge with `in_valid`=0, `out_valid`, `base_we` and `force_user` are 0, whatever the other inputs hold.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and control bits are valid this cycle |
| base | input | 32 | Base register value |
| off_is_reg | input | 1 | 0: immediate offset, 1: shifted register offset |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Offset register value |
| sh_kind | input | 2 | Shift type for the register offset |
| sh_amt | input | 5 | Shift amount taken from the instruction |
| add_off | input | 1 | 1: add offset, 0: subtract offset |
| pre_idx | input | 1 | 1: pre-indexed, 0: post-indexed |
| wback | input | 1 | Writeback request / user-rights request when post-indexed |
| priv | input | 1 | Current code runs privileged |
| out_valid | output | 1 | Result registers hold a new result |
| xfer_addr | output | 32 | Memory transfer address |
| new_base | output | 32 | Changed base value |
| base_we | output | 1 | Write `new_base` back to the base register |
| force_user | output | 1 | Perform the access with user rights |

## Verification
The hardest case to reach is where the second role of the writeback bit shows up. It needs a post-indexed transfer from privileged code with the bit set. The same bit must also be shown to mean nothing for privilege in the pre-indexed form and in user mode. The vector table walks all four pairs of indexing mode and writeback bit under privileged code, plus user-mode cases, with an offset that is not zero. A bad address, a missed writeback or a wrong rights flag then each show up at a different output. The wrap cases are also not obvious. An arithmetic right shift fills a negative operand with ones, and adding that result to a base makes the sum overflow exactly to zero. Subtracting past zero makes the address wrap to the top of the address space.

// File: rtl/ls_addr_gen_pkg.sv
package ls_addr_gen_pkg;

   typedef enum logic [1:0] {
      SHK_LSL = 2'b00,
      SHK_LSR = 2'b01,
      SHK_ASR = 2'b10,
      SHK_ROR = 2'b11
   } shk_e;

   typedef struct packed {
      logic add_off;
      logic pre_idx;
      logic wback;
      logic priv;
   } idx_ctrl_t;

   localparam int SHIFT_IMPL_STAGED = 0;
   localparam int SHIFT_IMPL_DIRECT = 1;

endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter
   import ls_addr_gen_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SHIFT_IMPL = SHIFT_IMPL_STAGED,
   localparam int SHW       = $clog2(DATA_W)
)(
   input  logic [DATA_W-1:0] op_i,
   input  shk_e              kind_i,
   input  logic [SHW-1:0]    amt_i,
   output logic [DATA_W-1:0] res_o
);

   if ((1 << SHW) != DATA_W) begin : g_bad_width
      $error("lsag_shifter: DATA_W must be a power of two");
   end

   if (SHIFT_IMPL == SHIFT_IMPL_STAGED) begin : g_staged
      logic [SHW:0][DATA_W-1:0] stg;
      assign stg[0] = op_i;

      for (genvar s = 0; s < SHW; s++) begin : g_stage
         localparam int D = 1 << s;
         always_comb begin
            stg[s+1] = stg[s];
            if (amt_i[s]) begin
               unique case (kind_i)
                  SHK_LSL: stg[s+1] = {stg[s][DATA_W-1-D:0], {D{1'b0}}};
                  SHK_LSR: stg[s+1] = {{D{1'b0}}, stg[s][DATA_W-1:D]};
                  SHK_ASR: stg[s+1] = {{D{stg[s][DATA_W-1]}}, stg[s][DATA_W-1:D]};
                  SHK_ROR: stg[s+1] = {stg[s][D-1:0], stg[s][DATA_W-1:D]};
                  default: stg[s+1] = stg[s];
               endcase
            end
         end
      end

      assign res_o = stg[SHW];
   end else begin : g_direct
      logic [SHW:0] back_amt;
      assign back_amt = (SHW+1)'(DATA_W) - {1'b0, amt_i};

      always_comb begin
         unique case (kind_i)
            SHK_LSL: res_o = op_i << amt_i;
            SHK_LSR: res_o = op_i >> amt_i;
            SHK_ASR: res_o = $unsigned($signed(op_i) >>> amt_i);
            SHK_ROR: res_o = (amt_i == '0) ? op_i
                                           : ((op_i >> amt_i) | (op_i << back_amt));
            default: res_o = op_i;
         endcase
      end
   end

endmodule

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel
   import ls_addr_gen_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 12,
   parameter int SHIFT_IMPL = SHIFT_IMPL_STAGED,
   localparam int SHW       = $clog2(DATA_W)
)(
   input  logic              use_reg_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [DATA_W-1:0] reg_i,
   input  shk_e              kind_i,
   input  logic [SHW-1:0]    amt_i,
   output logic [DATA_W-1:0] off_o
);

   if (IMM_W > DATA_W) begin : g_bad_imm
      $error("lsag_offset_sel: IMM_W may not exceed DATA_W");
   end

   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] imm_ext;

   lsag_shifter #(
      .DATA_W     (DATA_W),
      .SHIFT_IMPL (SHIFT_IMPL)
   ) u_shift (
      .op_i   (reg_i),
      .kind_i (kind_i),
      .amt_i  (amt_i),
      .res_o  (shifted)
   );

   if (IMM_W == DATA_W) begin : g_imm_full
      assign imm_ext = imm_i;
   end else begin : g_imm_pad
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_i};
   end

   assign off_o = use_reg_i ? shifted : imm_ext;

endmodule

// File: rtl/lsag_index_calc.sv
module lsag_index_calc
   import ls_addr_gen_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic [DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0] off_i,
   input  idx_ctrl_t         ctl_i,
   output logic [DATA_W-1:0] addr_o,
   output logic [DATA_W-1:0] nbase_o,
   output logic              we_o,
   output logic              user_o
);

   logic [DATA_W-1:0] moved;
   logic              post;

   always_comb begin
      if (ctl_i.add_off) moved = base_i + off_i;
      else               moved = base_i - off_i;
   end

   assign post    = ~ctl_i.pre_idx;
   assign nbase_o = moved;
   assign addr_o  = ctl_i.pre_idx ? moved : base_i;
   assign we_o    = post | ctl_i.wback;
   assign user_o  = ~ctl_i.priv | (post & ctl_i.wback);

endmodule

// File: rtl/lsag_out_reg.sv
module lsag_out_reg #(
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [DATA_W-1:0] addr_i,
   input  logic [DATA_W-1:0] nbase_i,
   input  logic              we_i,
   input  logic              user_i,
   output logic              vld_o,
   output logic [DATA_W-1:0] addr_o,
   output logic [DATA_W-1:0] nbase_o,
   output logic              we_o,
   output logic              user_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o   <= 1'b0;
         we_o    <= 1'b0;
         user_o  <= 1'b0;
         addr_o  <= '0;
         nbase_o <= '0;
      end else begin
         vld_o  <= vld_i;
         we_o   <= vld_i & we_i;
         user_o <= vld_i & user_i;
         if (vld_i) begin
            addr_o  <= addr_i;
            nbase_o <= nbase_i;
         end
      end
   end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
   import ls_addr_gen_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 12,
   parameter int SHIFT_IMPL = SHIFT_IMPL_STAGED,
   localparam int SHW       = $clog2(DATA_W)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] base,
   input  logic              off_is_reg,
   input  logic [IMM_W-1:0]  imm_off,
   input  logic [DATA_W-1:0] reg_off,
   input  logic [1:0]        sh_kind,
   input  logic [SHW-1:0]    sh_amt,
   input  logic              add_off,
   input  logic              pre_idx,
   input  logic              wback,
   input  logic              priv,
   output logic              out_valid,
   output logic [DATA_W-1:0] xfer_addr,
   output logic [DATA_W-1:0] new_base,
   output logic              base_we,
   output logic              force_user
);

   if (SHIFT_IMPL != SHIFT_IMPL_STAGED && SHIFT_IMPL != SHIFT_IMPL_DIRECT) begin : g_bad_impl
      $error("ls_addr_gen: unknown SHIFT_IMPL");
   end

   logic [DATA_W-1:0] offset;
   logic [DATA_W-1:0] c_addr;
   logic [DATA_W-1:0] c_nbase;
   logic              c_we;
   logic              c_user;
   idx_ctrl_t         ctl;

   assign ctl = '{add_off: add_off, pre_idx: pre_idx, wback: wback, priv: priv};

   lsag_offset_sel #(
      .DATA_W     (DATA_W),
      .IMM_W      (IMM_W),
      .SHIFT_IMPL (SHIFT_IMPL)
   ) u_off (
      .use_reg_i (off_is_reg),
      .imm_i     (imm_off),
      .reg_i     (reg_off),
      .kind_i    (shk_e'(sh_kind)),
      .amt_i     (sh_amt),
      .off_o     (offset)
   );

   lsag_index_calc #(
      .DATA_W (DATA_W)
   ) u_idx (
      .base_i  (base),
      .off_i   (offset),
      .ctl_i   (ctl),
      .addr_o  (c_addr),
      .nbase_o (c_nbase),
      .we_o    (c_we),
      .user_o  (c_user)
   );

   lsag_out_reg #(
      .DATA_W (DATA_W)
   ) u_oreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (in_valid),
      .addr_i  (c_addr),
      .nbase_i (c_nbase),
      .we_i    (c_we),
      .user_i  (c_user),
      .vld_o   (out_valid),
      .addr_o  (xfer_addr),
      .nbase_o (new_base),
      .we_o    (base_we),
      .user_o  (force_user)
   );

endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] base,
   input logic              pre_idx,
   input logic              wback,
   input logic              priv,
   input logic              out_valid,
   input logic [DATA_W-1:0] xfer_addr,
   input logic [DATA_W-1:0] new_base,
   input logic              base_we,
   input logic              force_user
);

   // R7
   valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !base_we && !force_user));

   // R4
   pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pre_idx) |=> (xfer_addr == new_base));

   // R4
   post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pre_idx) |=> (xfer_addr == $past(base)));

   // R5
   post_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (!pre_idx || wback)) |=> base_we);

   // R5
   pre_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pre_idx && !wback) |=> !base_we);

   // R6
   user_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (!priv || (!pre_idx && wback))) |=> force_user);

   // R6
   priv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && priv && (pre_idx || !wback)) |=> !force_user);

endmodule

bind ls_addr_gen lsag_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .base       (base),
   .pre_idx    (pre_idx),
   .wback      (wback),
   .priv       (priv),
   .out_valid  (out_valid),
   .xfer_addr  (xfer_addr),
   .new_base   (new_base),
   .base_we    (base_we),
   .force_user (force_user)
);

// File: tb/sim_ls_addr_gen.sv
module sim_ls_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] base = '0;
   logic        off_is_reg = 1'b0;
   logic [11:0] imm_off = '0;
   logic [31:0] reg_off = '0;
   logic [1:0]  sh_kind = '0;
   logic [4:0]  sh_amt = '0;
   logic        add_off = 1'b0;
   logic        pre_idx = 1'b0;
   logic        wback = 1'b0;
   logic        priv = 1'b0;
   logic        out_valid;
   logic [31:0] xfer_addr;
   logic [31:0] new_base;
   logic        base_we;
   logic        force_user;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ls_addr_gen u0 (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .base (base),
      .off_is_reg (off_is_reg), .imm_off (imm_off), .reg_off (reg_off),
      .sh_kind (sh_kind), .sh_amt (sh_amt), .add_off (add_off),
      .pre_idx (pre_idx), .wback (wback), .priv (priv),
      .out_valid (out_valid), .xfer_addr (xfer_addr), .new_base (new_base),
      .base_we (base_we), .force_user (force_user)
   );

   typedef struct packed {
      logic [31:0] b;
      logic        ur;
      logic [11:0] im;
      logic [31:0] rm;
      logic [1:0]  k;
      logic [4:0]  a;
      logic        up;
      logic        pr;
      logic        wb;
      logic        pv;
      logic [31:0] e_addr;
      logic [31:0] e_nb;
      logic        e_we;
      logic        e_fu;
   } vec_t;

   localparam int NV = 13;
   // fields: base, use_reg, imm, reg, kind, amt, up, pre, wb, priv, addr, new_base, we, user
   localparam vec_t VECS [NV] = '{
      // R1 immediate used, register ignored; R4/R5 pre without writeback
      '{32'h0000_1000, 1'b0, 12'h004, 32'hDEAD_BEEF, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1,
        32'h0000_1004, 32'h0000_1004, 1'b0, 1'b0},
      // R3 subtract, R5 pre with writeback
      '{32'h0000_1000, 1'b0, 12'h010, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1,
        32'h0000_0FF0, 32'h0000_0FF0, 1'b1, 1'b0},
      // R4 post uses old base, R5 post always writes back
      '{32'h0000_2000, 1'b0, 12'h008, 32'h0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1,
        32'h0000_2000, 32'h0000_2008, 1'b1, 1'b0},
      // R6 post + wb in privileged code forces user rights
      '{32'h0000_2000, 1'b0, 12'h008, 32'h0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b1, 1'b1,
        32'h0000_2000, 32'h0000_2008, 1'b1, 1'b1},
      // R6 user mode, pre + wb
      '{32'h0000_2000, 1'b0, 12'h008, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0,
        32'h0000_2008, 32'h0000_2008, 1'b1, 1'b1},
      // R1 register used, immediate ignored; R2 logical left by 4
      '{32'h0000_0100, 1'b1, 12'hFFF, 32'h0000_0003, 2'd0, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1,
        32'h0000_0130, 32'h0000_0130, 1'b0, 1'b0},
      // R2 logical right by 31, R3 subtract
      '{32'h0000_0010, 1'b1, 12'h000, 32'h8000_0000, 2'd1, 5'd31, 1'b0, 1'b1, 1'b0, 1'b1,
        32'h0000_000F, 32'h0000_000F, 1'b0, 1'b0},
      // R2 arithmetic right fills ones, R3 sum wraps to zero
      '{32'h0800_0000, 1'b1, 12'h000, 32'h8000_0000, 2'd2, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1,
        32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
      // R2 rotate right by 4, post-indexed
      '{32'h0000_0000, 1'b1, 12'h000, 32'h0000_00F1, 2'd3, 5'd4, 1'b1, 1'b0, 1'b0, 1'b1,
        32'h0000_0000, 32'h1000_000F, 1'b1, 1'b0},
      // R3 subtraction wraps below zero
      '{32'h0000_0004, 1'b0, 12'h008, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1,
        32'hFFFF_FFFC, 32'hFFFF_FFFC, 1'b0, 1'b0},
      // R1 full immediate, R3 wraps to zero
      '{32'hFFFF_F001, 1'b0, 12'hFFF, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1,
        32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
      // R2 amount zero passes through (logical right)
      '{32'h0000_0000, 1'b1, 12'h000, 32'h0000_0055, 2'd1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1,
        32'h0000_0055, 32'h0000_0055, 1'b0, 1'b0},
      // R6 user mode, post without wb; R2 rotate by zero
      '{32'h0000_3000, 1'b1, 12'h000, 32'h8000_0001, 2'd3, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0,
        32'h0000_3000, 32'h8000_2FFF, 1'b1, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v, input logic vld);
      base = v.b; off_is_reg = v.ur; imm_off = v.im; reg_off = v.rm;
      sh_kind = v.k; sh_amt = v.a; add_off = v.up; pre_idx = v.pr;
      wback = v.wb; priv = v.pv; in_valid = vld;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R7 watchdog expired act=0 exp=1");
         finish_run();
      end
   end

   initial begin
      // R9 outputs zero while reset held, even with a valid input
      drive(VECS[3], 1'b1);
      repeat (3) @(negedge clk);
      chk("R9 out_valid in reset", {31'b0, out_valid}, 32'd0);
      chk("R9 xfer_addr in reset", xfer_addr, 32'd0);
      chk("R9 new_base in reset", new_base, 32'd0);
      chk("R9 flags in reset", {30'b0, base_we, force_user}, 32'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: back-to-back operations, one-cycle latency (R7)
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i], 1'b1);
         @(negedge clk);
         chk($sformatf("R7 out_valid vec%0d", i), {31'b0, out_valid}, 32'd1);
         chk($sformatf("R1/R2/R3/R4 xfer_addr vec%0d", i), xfer_addr, VECS[i].e_addr);
         chk($sformatf("R1/R2/R3/R4 new_base vec%0d", i), new_base, VECS[i].e_nb);
         chk($sformatf("R5 base_we vec%0d", i), {31'b0, base_we}, {31'b0, VECS[i].e_we});
         chk($sformatf("R6 force_user vec%0d", i), {31'b0, force_user}, {31'b0, VECS[i].e_fu});
      end

      // R8 idle: stimulus that would set both flags, but in_valid low
      drive(VECS[3], 1'b0);
      @(negedge clk);
      chk("R8 out_valid idle", {31'b0, out_valid}, 32'd0);
      chk("R8 base_we idle", {31'b0, base_we}, 32'd0);
      chk("R8 force_user idle", {31'b0, force_user}, 32'd0);

      // R7 result tracks the cycle of its own valid input after a gap
      drive(VECS[2], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R7 latency after gap addr", xfer_addr, 32'h0000_2000);
      chk("R7 latency after gap valid", {31'b0, out_valid}, 32'd1);
      @(negedge clk);
      chk("R7 valid drops after one cycle", {31'b0, out_valid}, 32'd0);

      // R9 asynchronous reset clears outputs mid-run
      drive(VECS[3], 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      #1;
      chk("R9 reset mid-run addr", xfer_addr, 32'd0);
      chk("R9 reset mid-run flags", {29'b0, out_valid, base_we, force_user}, 32'd0);

      finish_run();
   end

endmodule